// File: doc/BRIEF.md
# Smart Card Serial Channel Status Flags

This block holds the status flags of a half-duplex, smart-card-style serial channel. Seven flags are kept: transmit-empty, receive-full, overrun, error-signal, parity-error, transmit-end and the received multiprocessor bit. There is also one read/write bit that supplies the multiprocessor bit to transmit. The serial shifters, the baud generator, the DMA engine and the interrupt logic live elsewhere. They reach this block as one-cycle strobes: character loaded into the shifter, character finished, reception done, error signal sampled, DMA access, and a half-bit-time tick. The tick runs at twice the bit rate so that delays in half bit times can be counted.

Software clears a clearable flag by reading the status while the flag is 1 and then writing 0 to that bit. A read re-arms the clear permission of every bit from the value that read returned. After a character has been sent, transmit-end rises only after a guard delay that depends on two mode inputs. The first mode input selects the guard-time handling and the second selects block transfer. The receive data register sits here too, because overrun and parity errors must leave it untouched.

Top module: `sc_status_flags`

## Requirements
- R1: A clearable flag (status bits 0 to 4) clears only when a write puts 0 on its bit and the most recent status read returned that bit as 1. A 0 written without such a read, or a 1 written, leaves the flag unchanged.
- R2: A reception done with no overrun and no parity error loads the receive data output with the character and sets receive-full (bit 1). A DMA read strobe clears receive-full.
- R3: A reception done while receive-full is 1 sets overrun (bit 2). The receive data output and receive-full keep their values.
- R4: When the parity selection is 1, the data bits plus the parity bit must contain an odd number of ones; when it is 0, an even number. A mismatch sets parity-error (bit 4) and leaves the receive data output and receive-full unchanged.
- R5: The error-sampled strobe sets error-signal (bit 3). Driving transmit-enable low does not change it. While it is 1, neither transmit-enable low nor a finished character sets transmit-end.
- R6: Transmit-empty (bit 0) sets while transmit-enable is 0 and on each shifter-load strobe. It clears on a DMA write strobe or through R1.
- R7: A character finishing while transmit-empty is 1 and error-signal is 0 sets transmit-end (bit 5) on the Nth following half-bit tick. N is 5 when guard mode is 0 and block mode is 0, 3 when guard mode is 0 and block mode is 1, and 2 when guard mode is 1.
- R8: A shifter-load strobe cancels a pending transmit-end countdown. A character finishing while transmit-empty is 0 starts no countdown. Transmit-end clears whenever transmit-empty is cleared.
- R9: Bit 6 copies the multiprocessor bit of each character that loads under R2 and cannot be written. Bit 7 takes bit 7 of every status write.
- R10: Reset or the stop input sets the status to 8'h21 (only bits 0 and 5 set) and the receive data output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Standby or module stop; returns all flags to their reset values |
| rd_en_i | input | 1 | Status register read strobe |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 8 | Status write data |
| tx_en_i | input | 1 | Transmit enable |
| guard_mode_i | input | 1 | Guard-time mode selection |
| block_mode_i | input | 1 | Block transfer mode selection |
| half_tick_i | input | 1 | Strobe at twice the bit rate |
| tx_load_i | input | 1 | Transmit data moved into the shifter |
| tx_done_i | input | 1 | Last bit of a transmitted character sent |
| dma_tx_wr_i | input | 1 | DMA write to the transmit data register |
| dma_rx_rd_i | input | 1 | DMA read of the receive data register |
| rx_done_i | input | 1 | Reception of a character finished |
| rx_data_i | input | DATA_W | Received character |
| rx_par_i | input | 1 | Received parity bit |
| rx_mpb_i | input | 1 | Received multiprocessor bit |
| par_odd_i | input | 1 | Parity selection: 1 odd, 0 even |
| err_seen_i | input | 1 | Low level of the error signal sampled |
| status_o | output | 8 | Status register contents |
| rx_data_o | output | DATA_W | Receive data register |

## Verification
The bench builds the block with its default parameters: 8-bit characters and guard delays of 5, 3 and 2 half ticks. These short delays let every mode combination be counted tick by tick, so the bench can check that transmit-end is still 0 one tick before its deadline and 1 on it. An 8-bit character is wide enough that both an even and an odd ones count can be chosen for the parity checks.

// File: rtl/sc_flag_pkg.sv
package sc_flag_pkg;
  localparam int B_TXE  = 0;
  localparam int B_RXF  = 1;
  localparam int B_OVR  = 2;
  localparam int B_ESIG = 3;
  localparam int B_PERR = 4;
  localparam int B_TEND = 5;
  localparam int B_MPR  = 6;
  localparam int B_MPT  = 7;
  localparam int N_CLR  = 5;
  localparam logic [7:0] STATUS_RESET = 8'h21;

  // number of half ticks between character end and transmit-end
  function automatic int tend_half_steps(input logic guard, input logic blk,
                                         input int h_norm, input int h_blk, input int h_guard);
    return guard ? h_guard : (blk ? h_blk : h_norm);
  endfunction

  // 1 when the ones count of data plus parity disagrees with the selection
  function automatic logic parity_bad(input logic [63:0] data, input logic par, input logic odd);
    return ((^data) ^ par) != odd;
  endfunction
endpackage

// File: rtl/sc_clr_gate.sv
module sc_clr_gate #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop_i,
  input  logic         rd_en_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_bits_i,
  input  logic [N-1:0] flags_i,
  output logic [N-1:0] clr_o
);
  logic [N-1:0] arm_q;

  assign clr_o = {N{wr_en_i}} & arm_q & ~wr_bits_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arm_q <= '0;
    else if (stop_i)  arm_q <= '0;
    else if (rd_en_i) arm_q <= flags_i;
    else              arm_q <= arm_q & flags_i & ~clr_o;
  end

  // R1: a clear pulse is never issued for a flag that is currently 0
  p_clr_only_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_o & ~flags_i) == '0));
endmodule

// File: rtl/sc_rx_flags.sv
module sc_rx_flags
  import sc_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              rx_mpb_i,
  input  logic              par_odd_i,
  input  logic              dma_rd_i,
  input  logic              clr_rxf_i,
  input  logic              clr_ovr_i,
  input  logic              clr_perr_i,
  output logic              rxf_o,
  output logic              ovr_o,
  output logic              perr_o,
  output logic              mpr_o,
  output logic              load_evt_o,
  output logic [DATA_W-1:0] rdr_o
);
  logic rxf_q, ovr_q, perr_q, mpr_q;
  logic [DATA_W-1:0] rdr_q;
  logic ovr_evt, perr_evt;

  assign ovr_evt    = rx_done_i && rxf_q;
  assign perr_evt   = rx_done_i && !rxf_q && parity_bad(64'(rx_data_i), rx_par_i, par_odd_i);
  assign load_evt_o = rx_done_i && !ovr_evt && !perr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || stop_i) begin
      rxf_q <= 1'b0; ovr_q <= 1'b0; perr_q <= 1'b0; mpr_q <= 1'b0; rdr_q <= '0;
    end else begin
      if (load_evt_o) begin
        rxf_q <= 1'b1;
        rdr_q <= rx_data_i;
        mpr_q <= rx_mpb_i;
      end else if (dma_rd_i || clr_rxf_i) begin
        rxf_q <= 1'b0;
      end
      if (ovr_evt)         ovr_q <= 1'b1;
      else if (clr_ovr_i)  ovr_q <= 1'b0;
      if (perr_evt)        perr_q <= 1'b1;
      else if (clr_perr_i) perr_q <= 1'b0;
    end
  end

  assign rxf_o  = rxf_q;
  assign ovr_o  = ovr_q;
  assign perr_o = perr_q;
  assign mpr_o  = mpr_q;
  assign rdr_o  = rdr_q;

  // R3: an overrun keeps the held character and the full flag
  p_ovr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && rxf_q && !dma_rd_i && !clr_rxf_i && !stop_i) |=> (rxf_q && $stable(rdr_q)));
  // R2: receive-full only falls through a DMA read, a clear or stop
  p_rxf_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxf_q) |-> $past(dma_rd_i || clr_rxf_i || stop_i));
endmodule

// File: rtl/sc_tend_timer.sv
module sc_tend_timer
  import sc_flag_pkg::*;
#(
  parameter int H_NORM  = 5,
  parameter int H_BLK   = 3,
  parameter int H_GUARD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic start_i,
  input  logic cancel_i,
  input  logic tick_i,
  input  logic guard_i,
  input  logic blk_i,
  output logic fire_o
);
  localparam int HMAX  = (H_NORM > H_BLK) ? ((H_NORM > H_GUARD) ? H_NORM : H_GUARD)
                                          : ((H_BLK > H_GUARD) ? H_BLK : H_GUARD);
  localparam int CNT_W = $clog2(HMAX + 1);

  logic [CNT_W-1:0] cnt_q;

  assign fire_o = tick_i && !cancel_i && !stop_i && !start_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (stop_i || cancel_i) cnt_q <= '0;
    else if (start_i)
      cnt_q <= CNT_W'(tend_half_steps(guard_i, blk_i, H_NORM, H_BLK, H_GUARD));
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  // R8: a cancelled countdown cannot fire on the next cycle
  p_cancel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_i && !start_i) |=> !fire_o);
endmodule

// File: rtl/sc_status_flags.sv
module sc_status_flags
  import sc_flag_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int H_NORM  = 5,
  parameter int H_BLK   = 3,
  parameter int H_GUARD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic              tx_en_i,
  input  logic              guard_mode_i,
  input  logic              block_mode_i,
  input  logic              half_tick_i,
  input  logic              tx_load_i,
  input  logic              tx_done_i,
  input  logic              dma_tx_wr_i,
  input  logic              dma_rx_rd_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              rx_mpb_i,
  input  logic              par_odd_i,
  input  logic              err_seen_i,
  output logic [7:0]        status_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic txe_q, esig_q, tend_q, mpt_q;
  logic rxf, ovr, perr, mpr, rx_load;
  logic [N_CLR-1:0] clr_flags, clr;
  logic txe_set, txe_clr, tend_fire, tend_set, tend_start;

  assign clr_flags = {perr, esig_q, ovr, rxf, txe_q};

  sc_clr_gate #(.N(N_CLR)) u_gate (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .wr_bits_i(wr_data_i[N_CLR-1:0]), .flags_i(clr_flags), .clr_o(clr));

  sc_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .rx_done_i(rx_done_i),
    .rx_data_i(rx_data_i), .rx_par_i(rx_par_i), .rx_mpb_i(rx_mpb_i),
    .par_odd_i(par_odd_i), .dma_rd_i(dma_rx_rd_i), .clr_rxf_i(clr[B_RXF]),
    .clr_ovr_i(clr[B_OVR]), .clr_perr_i(clr[B_PERR]), .rxf_o(rxf), .ovr_o(ovr),
    .perr_o(perr), .mpr_o(mpr), .load_evt_o(rx_load), .rdr_o(rx_data_o));

  assign tend_start = tx_done_i && txe_q && !esig_q;

  sc_tend_timer #(.H_NORM(H_NORM), .H_BLK(H_BLK), .H_GUARD(H_GUARD)) u_tend (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .start_i(tend_start),
    .cancel_i(tx_load_i), .tick_i(half_tick_i), .guard_i(guard_mode_i),
    .blk_i(block_mode_i), .fire_o(tend_fire));

  assign txe_set  = !tx_en_i || tx_load_i;
  assign txe_clr  = clr[B_TXE] || dma_tx_wr_i;
  assign tend_set = (!tx_en_i && !esig_q) || tend_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || stop_i) begin
      txe_q <= 1'b1; esig_q <= 1'b0; tend_q <= 1'b1; mpt_q <= 1'b0;
    end else begin
      if (txe_set)      txe_q <= 1'b1;
      else if (txe_clr) txe_q <= 1'b0;
      if (err_seen_i)         esig_q <= 1'b1;
      else if (clr[B_ESIG])   esig_q <= 1'b0;
      if (tend_set)           tend_q <= 1'b1;
      else if (txe_clr)       tend_q <= 1'b0;
      if (wr_en_i)            mpt_q <= wr_data_i[B_MPT];
    end
  end

  always_comb begin
    status_o         = '0;
    status_o[B_TXE]  = txe_q;
    status_o[B_RXF]  = rxf;
    status_o[B_OVR]  = ovr;
    status_o[B_ESIG] = esig_q;
    status_o[B_PERR] = perr;
    status_o[B_TEND] = tend_q;
    status_o[B_MPR]  = mpr;
    status_o[B_MPT]  = mpt_q;
  end

  // R6: transmit disabled forces transmit-empty on the next cycle
  p_te_off_txe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |=> txe_q);
  // R7: transmit-end rises only from the timer, transmit disable or stop
  p_tend_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend_q) |-> $past(tend_fire || (!tx_en_i && !esig_q) || stop_i));
  // R5: error-signal holds against everything but its own clear and stop
  p_esig_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (esig_q && !clr[B_ESIG] && !stop_i) |=> esig_q);
  // R9: a write never alters the received multiprocessor bit
  p_mpr_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !rx_load && !stop_i) |=> $stable(mpr));
endmodule

// File: tb/sim_sc_status_flags.sv
module sim_sc_status_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_i = 0, rd_en_i = 0, wr_en_i = 0, tx_en_i = 1, guard_mode_i = 0, block_mode_i = 0;
  logic half_tick_i = 0, tx_load_i = 0, tx_done_i = 0, dma_tx_wr_i = 0, dma_rx_rd_i = 0;
  logic rx_done_i = 0, rx_par_i = 0, rx_mpb_i = 0, par_odd_i = 0, err_seen_i = 0;
  logic [7:0] wr_data_i = 8'h00, rx_data_i = 8'h00;
  logic [7:0] status_o, rx_data_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sc_status_flags u0 (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .tx_en_i(tx_en_i), .guard_mode_i(guard_mode_i),
    .block_mode_i(block_mode_i), .half_tick_i(half_tick_i), .tx_load_i(tx_load_i),
    .tx_done_i(tx_done_i), .dma_tx_wr_i(dma_tx_wr_i), .dma_rx_rd_i(dma_rx_rd_i),
    .rx_done_i(rx_done_i), .rx_data_i(rx_data_i), .rx_par_i(rx_par_i),
    .rx_mpb_i(rx_mpb_i), .par_odd_i(par_odd_i), .err_seen_i(err_seen_i),
    .status_o(status_o), .rx_data_o(rx_data_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic cyc(); @(negedge clk); endtask
  task automatic do_read(); rd_en_i = 1; cyc(); rd_en_i = 0; endtask
  task automatic do_write(input logic [7:0] d);
    wr_data_i = d; wr_en_i = 1; cyc(); wr_en_i = 0;
  endtask
  task automatic tick(); half_tick_i = 1; cyc(); half_tick_i = 0; endtask
  task automatic load(); tx_load_i = 1; cyc(); tx_load_i = 0; endtask
  task automatic done(); tx_done_i = 1; cyc(); tx_done_i = 0; endtask
  task automatic rx(input logic [7:0] d, input logic p, input logic m);
    rx_data_i = d; rx_par_i = p; rx_mpb_i = m; rx_done_i = 1; cyc(); rx_done_i = 0;
  endtask
  // clear transmit-empty (and with it transmit-end) by read then write
  task automatic drop_txe(); do_read(); do_write(8'h7E); endtask

  function automatic int half_steps(input logic g, input logic b);
    if (g) return 2;
    if (b) return 3;
    return 5;
  endfunction

  task automatic t_reset();
    chk("R10 reset status", status_o, 8'h21);
    chk("R10 reset rdr", rx_data_o, 8'h00);
  endtask

  task automatic t_clear_rules();
    do_write(8'h00);
    chk("R1 zero write unarmed", status_o & 8'h01, 8'h01);
    do_read(); do_write(8'hFE);
    chk("R1 armed clear txe", status_o & 8'h21, 8'h00);
    load();
    chk("R6 load sets txe", status_o & 8'h01, 8'h01);
    dma_tx_wr_i = 1; cyc(); dma_tx_wr_i = 0;
    chk("R6 dma write clears txe", status_o & 8'h01, 8'h00);
    load();
  endtask

  task automatic t_tend(input logic g, input logic b);
    int n = half_steps(g, b);
    guard_mode_i = g; block_mode_i = b;
    drop_txe(); load();
    done();
    for (int i = 0; i < n - 1; i++) tick();
    chk("R7 tend before deadline", status_o & 8'h20, 8'h00);
    tick();
    chk("R7 tend on deadline", status_o & 8'h20, 8'h20);
  endtask

  task automatic t_cancel();
    guard_mode_i = 0; block_mode_i = 0;
    drop_txe();
    chk("R8 tend follows txe clear", status_o & 8'h21, 8'h00);
    load(); done(); tick(); tick(); load();
    for (int i = 0; i < 6; i++) tick();
    chk("R8 load cancels countdown", status_o & 8'h20, 8'h00);
    drop_txe(); done();
    for (int i = 0; i < 6; i++) tick();
    chk("R8 no countdown when txe low", status_o & 8'h20, 8'h00);
    load();
  endtask

  task automatic t_rx();
    par_odd_i = 0;
    rx(8'hA5, 1'b0, 1'b1);
    chk("R2 rxf set", status_o & 8'h02, 8'h02);
    chk("R2 rdr loaded", rx_data_o, 8'hA5);
    chk("R9 mpr follows rx", status_o & 8'h40, 8'h40);
    dma_rx_rd_i = 1; cyc(); dma_rx_rd_i = 0;
    chk("R2 dma read clears rxf", status_o & 8'h02, 8'h00);
    rx(8'h3C, 1'b0, 1'b0);
    rx(8'h0F, 1'b0, 1'b1);
    chk("R3 overrun set", status_o & 8'h46, 8'h06);
    chk("R3 rdr kept", rx_data_o, 8'h3C);
    do_read(); do_write(8'hF9);
    chk("R1 clear rxf and ovr", status_o & 8'h06, 8'h00);
  endtask

  task automatic t_parity();
    par_odd_i = 1;
    rx(8'h03, 1'b0, 1'b1);
    chk("R4 parity error set", status_o & 8'h52, 8'h10);
    chk("R4 rdr kept", rx_data_o, 8'h3C);
    do_write(8'hEF);
    chk("R1 perr kept without read", status_o & 8'h10, 8'h10);
    do_read(); do_write(8'hEF);
    chk("R1 perr cleared", status_o & 8'h10, 8'h00);
    rx(8'h07, 1'b0, 1'b0);
    chk("R4 odd count accepted", rx_data_o, 8'h07);
    do_read(); do_write(8'hFD);
    par_odd_i = 0;
  endtask

  task automatic t_esig();
    err_seen_i = 1; cyc(); err_seen_i = 0;
    chk("R5 esig set", status_o & 8'h08, 8'h08);
    tx_en_i = 0; cyc(); tx_en_i = 1;
    chk("R5 te low keeps esig no tend", status_o & 8'h29, 8'h09);
    done();
    for (int i = 0; i < 6; i++) tick();
    chk("R5 esig blocks tend", status_o & 8'h20, 8'h00);
    do_read(); do_write(8'hF7);
    chk("R5 esig cleared", status_o & 8'h08, 8'h00);
  endtask

  task automatic t_mpb();
    do_write(8'h7F);
    chk("R9 mpt written 0", status_o & 8'hC0, 8'h00);
    do_write(8'hFF);
    chk("R9 mpr read only", status_o & 8'hC0, 8'h80);
  endtask

  task automatic t_stop();
    err_seen_i = 1; cyc(); err_seen_i = 0;
    stop_i = 1; cyc(); stop_i = 0;
    chk("R10 stop status", status_o, 8'h21);
    chk("R10 stop rdr", rx_data_o, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    t_reset();
    t_clear_rules();
    t_tend(1'b0, 1'b0);
    t_tend(1'b0, 1'b1);
    t_tend(1'b1, 1'b0);
    t_tend(1'b1, 1'b1);
    t_cancel();
    t_rx();
    t_parity();
    t_esig();
    t_mpb();
    t_stop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule